// File: doc/BRIEF.md
# Priority Chip-Select Decoder

This block generates the external-bus chip selects for an 8-bit microcontroller. It takes the upper byte of the CPU address, the address-valid strobe, the E clock and the hit flags from the bank-window logic and the internal memories. From these it drives four select pins: an I/O select, a program select and two general-purpose selects. It also drives a stretch request that holds the bus for extra cycles on slow devices.

A byte-wide write port loads six configuration registers. The general-purpose selects have these settings:
- a start page and a power-of-two size;
- an active level;
- qualification by the E clock or by address valid;
- an option to follow an expansion window whatever bank is mapped;
- a stretch length of 0 to 3 cycles.

A select can be rerouted so that it is ORed onto another select's pin. One priority bit picks between two fixed orders that settle overlaps with each other and with internal memories. All decoding works on inputs registered once, so each output reflects the inputs captured at the previous clock edge.

Top module: `chip_select_unit`

## Requirements
- R1: After reset every register is 0, so all four select pins are high and stretch_o is low. A write at cfg_addr_i 0..5 loads, in order: control, GP1 start page, GP1 config, GP2 start page, GP2 config, routing. Addresses 6 and 7 are ignored. Each pin reflects the inputs sampled on the previous rising clock edge.
- R2: The control byte has io_en in bit 7, io_active_high in bit 6, io_base in bit 5, io_size in bit 4, priority in bit 3, prog_en in bit 2 and prog_size in bits 1:0. When io_en is 0 the I/O select never activates. io_active_high 0 means the select is active low; 1 means active high.
- R3: The I/O select covers pages 0x02 (io_base=0) or 0x04 (io_base=1). It covers one page (io_size=0) or two pages (io_size=1). It is qualified by addr_valid_i.
- R4: The program select is active low and qualified by addr_valid_i. When prog_en is set it covers the top 8K, 16K, 32K or all 64K of the address space for prog_size 0, 1, 2 or 3.
- R5: A GP select covers 2^code pages, with code in config bits 4:2. The region is aligned, and its start is the start page with its low code bits cleared. The select is on only when its enable bit is set: routing bit 4 for GP1, bit 5 for GP2.
- R6: In the GP config byte, bit 7 set means active high. Bit 6 set qualifies the select with e_clk_i; clear qualifies it with addr_valid_i.
- R7: With GP config bit 5 set, GP select n also activates whenever win_hit_i[n] is high and it is qualified, whatever the address.
- R8: stretch_o goes high in the first cycle a GP select wins and stays high for exactly the number of cycles in that select's config bits 1:0. Holding the same access longer does not restart it. I/O and program accesses never stretch.
- R9: Routing bit 0 sends GP1 to the program pin. Bit 1 sends GP1 to the GP2 pin, unless bit 0 is set. Bit 2 sends the GP2 pin's value to the program pin. A routed select leaves its own pin inactive, and the receiving pin is the OR of both decodes in the receiver's polarity.
- R10: int_hit_i bits are registers[0], RAM[1], bootloader[2], EEPROM[3] and ROM[4]. With priority 0 the order is registers, RAM, bootloader, EEPROM, ROM, I/O, GP1, GP2, program. With priority 1 it is registers, RAM, bootloader, I/O, GP1, GP2, EEPROM, ROM, program. Only the top requester is granted.
- R11: A select that is idle, disabled or loses arbitration drives its inactive level according to its own polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register index |
| cfg_wdata_i | input | 8 | Configuration write data |
| addr_hi_i | input | 8 | Upper CPU address byte (page number) |
| addr_valid_i | input | 1 | Address valid strobe |
| e_clk_i | input | 1 | E clock phase |
| win_hit_i | input | 2 | Expansion window n is addressed |
| int_hit_i | input | 5 | Internal resource hits |
| io_cs_o | output | 1 | I/O select pin |
| prog_cs_o | output | 1 | Program select pin, active low |
| gp_cs_o | output | 2 | General-purpose select pins |
| stretch_o | output | 1 | Bus stretch request |

## Verification
Some properties are checked on every cycle:
- the arbiter grants at most one target and only a requester;
- a bootloader, RAM or register hit leaves every pin inactive;
- with priority 0, a ROM or EEPROM hit keeps both GP pins inactive;
- a disabled I/O select stays at its idle level;
- a running stretch count drops by one per cycle.

Other behaviour shows only in the bench's scenarios: the region edges for each size code, base and alignment, the swap of the two priority orders, the OR routing onto another pin, window following, and the exact stretch length for each setting.

// File: rtl/csu_pkg.sv
package csu_pkg;
  localparam int unsigned NUM_GP    = 2;
  localparam int unsigned NUM_TGT   = 9;
  localparam int unsigned STRETCH_W = 2;

  typedef enum int unsigned {
    T_REGS = 0, T_RAM = 1, T_BOOT = 2, T_EEPROM = 3, T_ROM = 4,
    T_IO = 5, T_GP1 = 6, T_GP2 = 7, T_PROG = 8
  } tgt_e;

  typedef struct packed {
    logic                 io_en;
    logic                 io_act_high;
    logic                 io_base;
    logic                 io_size;
    logic                 prio;
    logic                 prog_en;
    logic [1:0]           prog_size;
  } ctl_t;

  typedef struct packed {
    logic                 act_high;
    logic                 e_qual;
    logic                 follow;
    logic [2:0]           size_code;
    logic [STRETCH_W-1:0] stretch;
  } gp_cfg_t;

  typedef struct packed {
    logic [NUM_GP-1:0]    gp_en;
    logic                 gp2_to_prog;
    logic                 gp1_to_gp2;
    logic                 gp1_to_prog;
  } route_t;

  // rank -> target; priority 1 lifts I/O and GP above EEPROM/ROM
  function automatic int unsigned rank_to_tgt(input logic prio, input int unsigned rank);
    int unsigned t;
    t = rank;
    if (prio) begin
      case (rank)
        3: t = T_IO;
        4: t = T_GP1;
        5: t = T_GP2;
        6: t = T_EEPROM;
        7: t = T_ROM;
        default: t = rank;
      endcase
    end
    return t;
  endfunction
endpackage

// File: rtl/csu_regs.sv
module csu_regs
  import csu_pkg::*;
#(
  parameter int unsigned REG_AW = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [REG_AW-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output ctl_t                         ctl_o,
  output logic [NUM_GP-1:0][DATA_W-1:0] gp_base_o,
  output gp_cfg_t [NUM_GP-1:0]         gp_cfg_o,
  output route_t                       route_o
);
  localparam int unsigned A_CTL   = 0;
  localparam int unsigned A_ROUTE = 1 + 2 * NUM_GP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o   <= '0;
      route_o <= '0;
    end else if (we_i) begin
      if (addr_i == REG_AW'(A_CTL))   ctl_o <= ctl_t'(wdata_i);
      if (addr_i == REG_AW'(A_ROUTE))
        route_o <= '{gp_en: wdata_i[5:4], gp2_to_prog: wdata_i[2],
                     gp1_to_gp2: wdata_i[1], gp1_to_prog: wdata_i[0]};
    end
  end

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp_regs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        gp_base_o[g] <= '0;
        gp_cfg_o[g]  <= '0;
      end else if (we_i) begin
        if (addr_i == REG_AW'(1 + 2 * g)) gp_base_o[g] <= wdata_i;
        if (addr_i == REG_AW'(2 + 2 * g)) gp_cfg_o[g]  <= gp_cfg_t'(wdata_i);
      end
    end
  end
endmodule

// File: rtl/csu_page_match.sv
module csu_page_match #(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned CODE_W = 4
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [PAGE_W-1:0] base_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              hit_o
);
  logic [PAGE_W-1:0] mask;
  // region of 2^code pages, aligned: low code bits are don't-care
  assign mask  = {PAGE_W{1'b1}} << code_i;
  assign hit_o = ((page_i ^ base_i) & mask) == '0;
endmodule

// File: rtl/csu_arbiter.sv
module csu_arbiter
  import csu_pkg::*;
(
  input  logic               prio_i,
  input  logic [NUM_TGT-1:0] req_i,
  output logic [NUM_TGT-1:0] grant_o
);
  always_comb begin
    logic        found;
    int unsigned t;
    found   = 1'b0;
    grant_o = '0;
    for (int unsigned r = 0; r < NUM_TGT; r++) begin
      t = rank_to_tgt(prio_i, r);
      if (!found && req_i[t]) begin
        grant_o[t] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/csu_stretch.sv
module csu_stretch
  import csu_pkg::*;
#(
  parameter int unsigned SW = STRETCH_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_GP-1:0]          start_i,
  input  logic [NUM_GP-1:0][SW-1:0]  len_i,
  output logic                       stretch_o
);
  logic [SW-1:0] cnt_q, cnt_d, len_sel;
  logic          any_start;

  always_comb begin
    any_start = |start_i;
    len_sel   = '0;
    for (int i = 0; i < NUM_GP; i++)
      if (start_i[i]) len_sel = len_i[i];
    if (any_start)         cnt_d = (len_sel == '0) ? '0 : len_sel - SW'(1);
    else if (cnt_q != '0)  cnt_d = cnt_q - SW'(1);
    else                   cnt_d = '0;
    stretch_o = (any_start && len_sel != '0) || cnt_q != '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assert_stretch_dec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !any_start) |=> (cnt_q == $past(cnt_q) - SW'(1)));
endmodule

// File: rtl/chip_select_unit.sv
module chip_select_unit
  import csu_pkg::*;
#(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned REG_AW = 3,
  parameter int unsigned INT_N  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [REG_AW-1:0] cfg_addr_i,
  input  logic [PAGE_W-1:0] cfg_wdata_i,
  input  logic [PAGE_W-1:0] addr_hi_i,
  input  logic              addr_valid_i,
  input  logic              e_clk_i,
  input  logic [NUM_GP-1:0] win_hit_i,
  input  logic [INT_N-1:0]  int_hit_i,
  output logic              io_cs_o,
  output logic              prog_cs_o,
  output logic [NUM_GP-1:0] gp_cs_o,
  output logic              stretch_o
);
  localparam int unsigned CODE_W = $clog2(PAGE_W + 1);
  localparam logic [PAGE_W-1:0] IO_BASE_LO = PAGE_W'(8'h02);
  localparam logic [PAGE_W-1:0] IO_BASE_HI = PAGE_W'(8'h04);
  localparam logic [PAGE_W-1:0] PROG_TOP   = {PAGE_W{1'b1}};
  localparam int unsigned       PROG_CODE0 = PAGE_W - 3;   // 8K of 64K

  ctl_t                          ctl;
  route_t                        route;
  gp_cfg_t [NUM_GP-1:0]          gp_cfg;
  logic [NUM_GP-1:0][PAGE_W-1:0] gp_base;

  csu_regs #(.REG_AW(REG_AW), .DATA_W(PAGE_W)) u_regs (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .ctl_o(ctl), .gp_base_o(gp_base), .gp_cfg_o(gp_cfg), .route_o(route)
  );

  // input capture
  logic [PAGE_W-1:0] page_q;
  logic              av_q, e_q;
  logic [NUM_GP-1:0] win_q;
  logic [INT_N-1:0]  int_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0; av_q <= 1'b0; e_q <= 1'b0; win_q <= '0; int_q <= '0;
    end else begin
      page_q <= addr_hi_i; av_q <= addr_valid_i; e_q <= e_clk_i;
      win_q  <= win_hit_i; int_q <= int_hit_i;
    end
  end

  // region decode
  logic io_hit, prog_hit;
  logic [NUM_GP-1:0] gp_req;

  csu_page_match #(.PAGE_W(PAGE_W), .CODE_W(CODE_W)) u_io_match (
    .page_i(page_q), .base_i(ctl.io_base ? IO_BASE_HI : IO_BASE_LO),
    .code_i(CODE_W'(ctl.io_size)), .hit_o(io_hit)
  );

  csu_page_match #(.PAGE_W(PAGE_W), .CODE_W(CODE_W)) u_prog_match (
    .page_i(page_q), .base_i(PROG_TOP),
    .code_i(CODE_W'(PROG_CODE0) + CODE_W'(ctl.prog_size)), .hit_o(prog_hit)
  );

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    logic hit;
    csu_page_match #(.PAGE_W(PAGE_W), .CODE_W(CODE_W)) u_match (
      .page_i(page_q), .base_i(gp_base[g]),
      .code_i(CODE_W'(gp_cfg[g].size_code)), .hit_o(hit)
    );
    assign gp_req[g] = route.gp_en[g] & (gp_cfg[g].e_qual ? e_q : av_q)
                     & (hit | (gp_cfg[g].follow & win_q[g]));
  end

  // arbitration
  logic [NUM_TGT-1:0] req, grant;
  always_comb begin
    req          = '0;
    req[INT_N-1:0] = int_q;
    req[T_IO]    = ctl.io_en & av_q & io_hit;
    req[T_GP1]   = gp_req[0];
    req[T_GP2]   = gp_req[1];
    req[T_PROG]  = ctl.prog_en & av_q & prog_hit;
  end

  csu_arbiter u_arb (.prio_i(ctl.prio), .req_i(req), .grant_o(grant));

  // OR routing onto pins
  logic gp1_routed, gp2_or, prog_act, io_act;
  logic [NUM_GP-1:0] gp_act, gp_idle;
  assign gp1_routed = route.gp1_to_prog | route.gp1_to_gp2;
  assign gp2_or     = grant[T_GP2] | (route.gp1_to_gp2 & ~route.gp1_to_prog & grant[T_GP1]);
  assign prog_act   = grant[T_PROG] | (route.gp1_to_prog & grant[T_GP1])
                    | (route.gp2_to_prog & gp2_or);
  assign gp_act[0]  = grant[T_GP1] & ~gp1_routed;
  assign gp_act[1]  = gp2_or & ~route.gp2_to_prog;
  assign io_act     = grant[T_IO];

  assign io_cs_o   = ctl.io_act_high ? io_act : ~io_act;
  assign prog_cs_o = ~prog_act;
  for (genvar g = 0; g < NUM_GP; g++) begin : g_pin
    assign gp_idle[g] = ~gp_cfg[g].act_high;
    assign gp_cs_o[g] = gp_act[g] ^ gp_idle[g];
  end

  // stretch on first winning cycle of a GP select
  logic [NUM_GP-1:0] gp_win, gp_win_q;
  logic [NUM_GP-1:0][STRETCH_W-1:0] gp_len;
  assign gp_win = grant[T_GP2:T_GP1];
  for (genvar g = 0; g < NUM_GP; g++) begin : g_len
    assign gp_len[g] = gp_cfg[g].stretch;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gp_win_q <= '0;
    else         gp_win_q <= gp_win;
  end

  csu_stretch u_stretch (
    .clk_i, .rst_ni, .start_i(gp_win & ~gp_win_q), .len_i(gp_len), .stretch_o(stretch_o)
  );

  assert_grant_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  assert_grant_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant & ~req) == '0);
  assert_int_block_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|int_q[2:0]) |-> (io_cs_o == ~ctl.io_act_high && prog_cs_o && gp_cs_o == gp_idle));
  assert_prio0_ext_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl.prio && (|int_q[4:3])) |-> (gp_cs_o == gp_idle));
  assert_io_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl.io_en |-> (io_cs_o == ~ctl.io_act_high));
endmodule

// File: tb/tb_chip_select_unit.sv
`timescale 1ns/1ps
module tb_chip_select_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] addr_hi = '0;
  logic       av = 1'b0, e = 1'b0;
  logic [1:0] win = '0;
  logic [4:0] ih = '0;
  logic       io_cs, prog_cs, stretch;
  logic [1:0] gp_cs;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chip_select_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .addr_hi_i(addr_hi), .addr_valid_i(av), .e_clk_i(e),
    .win_hit_i(win), .int_hit_i(ih), .io_cs_o(io_cs), .prog_cs_o(prog_cs),
    .gp_cs_o(gp_cs), .stretch_o(stretch)
  );

  // {tag, addr, av, e, win, int, exp{io,prog,gp2,gp1}}
  localparam logic [32:0] VEC [19] = '{
    {4'd3,  16'h0200, 1'b1, 1'b0, 2'b00, 5'b00000, 4'b1101},
    {4'd3,  16'h02FF, 1'b1, 1'b0, 2'b00, 5'b00000, 4'b1101},
    {4'd3,  16'h0300, 1'b1, 1'b0, 2'b00, 5'b00000, 4'b0101},
    {4'd3,  16'h0200, 1'b0, 1'b0, 2'b00, 5'b00000, 4'b0101},
    {4'd4,  16'hE000, 1'b1, 1'b0, 2'b00, 5'b00000, 4'b0001},
    {4'd4,  16'hDFFF, 1'b1, 1'b0, 2'b00, 5'b00000, 4'b0101},
    {4'd5,  16'h8000, 1'b1, 1'b0, 2'b00, 5'b00000, 4'b0100},
    {4'd5,  16'h8FFF, 1'b1, 1'b0, 2'b00, 5'b00000, 4'b0100},
    {4'd5,  16'h9000, 1'b1, 1'b0, 2'b00, 5'b00000, 4'b0101},
    {4'd6,  16'h8000, 1'b0, 1'b1, 2'b00, 5'b00000, 4'b0101},
    {4'd6,  16'h4000, 1'b0, 1'b1, 2'b00, 5'b00000, 4'b0111},
    {4'd6,  16'h41FF, 1'b1, 1'b0, 2'b00, 5'b00000, 4'b0101},
    {4'd5,  16'h4200, 1'b1, 1'b1, 2'b00, 5'b00000, 4'b0101},
    {4'd7,  16'h1234, 1'b0, 1'b1, 2'b10, 5'b00000, 4'b0111},
    {4'd7,  16'h1234, 1'b0, 1'b1, 2'b01, 5'b00000, 4'b0101},
    {4'd10, 16'h8000, 1'b1, 1'b0, 2'b00, 5'b10000, 4'b0101},
    {4'd10, 16'hE000, 1'b1, 1'b0, 2'b00, 5'b00001, 4'b0101},
    {4'd10, 16'h0200, 1'b1, 1'b1, 2'b10, 5'b00000, 4'b1101},
    {4'd11, 16'h1234, 1'b1, 1'b1, 2'b00, 5'b00000, 4'b0101}
  };

  function automatic string tag_s(input logic [3:0] n);
    case (n)
      4'd3: return "R3";   4'd4: return "R4";   4'd5: return "R5";
      4'd6: return "R6";   4'd7: return "R7";   4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_pins(input string tag, input logic [3:0] exp);
    chk(tag, {io_cs, prog_cs, gp_cs[1], gp_cs[0]}, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic apply(input logic [15:0] a, input logic v, input logic ee,
                       input logic [1:0] w, input logic [4:0] ii);
    @(negedge clk);
    addr_hi = a[15:8]; av = v; e = ee; win = w; ih = ii;
    @(negedge clk);
  endtask

  task automatic run_stretch(input logic [1:0] len);
    wr(3'd2, {6'b000100, len});
    apply(16'h1234, 1'b0, 1'b0, 2'b00, 5'b0);
    apply(16'h8000, 1'b1, 1'b0, 2'b00, 5'b0);
    chk("R8 first cycle", {3'b0, stretch}, {3'b0, len != 2'd0});
    addr_hi = 8'h12; av = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk("R8 hold", {3'b0, stretch}, {3'b0, k < int'(len)});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_pins("R1 reset pins", 4'b1111);
    chk("R1 reset stretch", {3'b0, stretch}, 4'b0);

    wr(3'd0, 8'hC4); wr(3'd1, 8'h80); wr(3'd2, 8'h10);
    wr(3'd3, 8'h40); wr(3'd4, 8'hE4); wr(3'd5, 8'h30);
    wr(3'd7, 8'hFF); wr(3'd6, 8'hFF);  // unmapped: ignored
    apply(16'h1234, 1'b1, 1'b0, 2'b00, 5'b0);
    chk_pins("R1 unmapped write ignored", 4'b0101);

    for (int i = 0; i < 19; i++) begin
      apply(VEC[i][28:13], VEC[i][12], VEC[i][11], VEC[i][10:9], VEC[i][8:4]);
      chk_pins(tag_s(VEC[i][32:29]), VEC[i][3:0]);
    end

    // R1 latency: output follows one edge after input
    @(negedge clk);
    addr_hi = 8'h80; av = 1'b1; e = 1'b0; win = '0; ih = '0;
    #1 chk_pins("R1 not yet captured", 4'b0101);
    @(negedge clk);
    chk_pins("R1 captured", 4'b0100);

    // R10 priority 1
    wr(3'd0, 8'hCC);
    apply(16'h8000, 1'b1, 1'b0, 2'b00, 5'b10000); chk_pins("R10 gp over rom", 4'b0100);
    apply(16'h8000, 1'b1, 1'b0, 2'b00, 5'b01000); chk_pins("R10 gp over eeprom", 4'b0100);
    apply(16'h8000, 1'b1, 1'b0, 2'b00, 5'b00001); chk_pins("R10 regs still win", 4'b0101);
    apply(16'h8000, 1'b1, 1'b0, 2'b00, 5'b00010); chk_pins("R10 ram still win", 4'b0101);
    apply(16'hE000, 1'b1, 1'b0, 2'b00, 5'b10000); chk_pins("R10 rom over prog", 4'b0101);
    wr(3'd0, 8'hC7);
    apply(16'h8000, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R10 gp over prog", 4'b0100);
    apply(16'h1234, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R4 prog 64K", 4'b0001);
    wr(3'd0, 8'hC4);

    // R9 routing
    wr(3'd5, 8'h31);
    apply(16'h8000, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R9 gp1 to prog", 4'b0001);
    apply(16'hE000, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R9 prog own", 4'b0001);
    wr(3'd5, 8'h32);
    apply(16'h8000, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R9 gp1 to gp2", 4'b0111);
    apply(16'h4000, 1'b0, 1'b1, 2'b00, 5'b0); chk_pins("R9 gp2 own", 4'b0111);
    wr(3'd5, 8'h34);
    apply(16'h4000, 1'b0, 1'b1, 2'b00, 5'b0); chk_pins("R9 gp2 to prog", 4'b0001);
    apply(16'h8000, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R9 gp1 unrouted", 4'b0100);
    wr(3'd5, 8'h36);
    apply(16'h8000, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R9 chain to prog", 4'b0001);
    wr(3'd5, 8'h20);
    apply(16'h8000, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R5 gp1 disabled", 4'b0101);
    wr(3'd5, 8'h30);

    // R2 / R6 / R11 polarity
    wr(3'd2, 8'h90);
    apply(16'h1234, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R11 gp1 high idle", 4'b0100);
    apply(16'h8000, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R6 gp1 active high", 4'b0101);
    wr(3'd2, 8'h10);
    wr(3'd0, 8'h84);
    apply(16'h1234, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R2 io low idle", 4'b1101);
    apply(16'h0200, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R2 io active low", 4'b0101);
    wr(3'd0, 8'h44);
    apply(16'h0200, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R2 io disabled", 4'b0101);

    // R3 base/size
    wr(3'd0, 8'hF4);
    apply(16'h05FF, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R3 top of 2 pages", 4'b1101);
    apply(16'h0400, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R3 high base", 4'b1101);
    apply(16'h0600, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R3 past end", 4'b0101);
    apply(16'h0200, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R3 low base off", 4'b0101);

    // R4 program sizes
    wr(3'd0, 8'hC5);
    apply(16'hC000, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R4 16K start", 4'b0001);
    apply(16'hBFFF, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R4 16K below", 4'b0101);
    wr(3'd0, 8'hC6);
    apply(16'hA000, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R4 32K inside", 4'b0001);
    apply(16'h7FFF, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R4 32K below", 4'b0101);
    wr(3'd0, 8'hC0);
    apply(16'hE000, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R4 prog disabled", 4'b0101);
    wr(3'd0, 8'hC4);

    // R5 alignment
    wr(3'd1, 8'h85); wr(3'd2, 8'h00);
    apply(16'h8500, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R5 one page", 4'b0100);
    apply(16'h8600, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R5 next page", 4'b0101);
    apply(16'h84FF, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R5 prev page", 4'b0101);
    wr(3'd2, 8'h1C);
    apply(16'h8000, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R5 aligned 32K", 4'b0100);
    apply(16'h7FFF, 1'b1, 1'b0, 2'b00, 5'b0); chk_pins("R5 below 32K", 4'b0101);
    wr(3'd1, 8'h80); wr(3'd2, 8'h10);

    // R8 stretch
    for (int l = 0; l < 4; l++) run_stretch(2'(l));
    apply(16'h0200, 1'b1, 1'b0, 2'b00, 5'b0);
    chk("R8 io no stretch", {3'b0, stretch}, 4'b0);
    apply(16'hE000, 1'b1, 1'b0, 2'b00, 5'b0);
    chk("R8 prog no stretch", {3'b0, stretch}, 4'b0);
    wr(3'd2, 8'h11);
    apply(16'h1234, 1'b0, 1'b0, 2'b00, 5'b0);
    apply(16'h8000, 1'b1, 1'b0, 2'b00, 5'b0);
    chk("R8 held first", {3'b0, stretch}, 4'b1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 held no restart", {3'b0, stretch}, 4'b0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule